// File: doc/BRIEF.md
# Link Clock, Reset and Power-Down Sequencer

This block sits on the codec side of a five-wire serial audio link. It decides when the codec produces its bit clock, and when the link engine may drive the serial input line and report itself ready to the controller. It runs from a free-running master clock at twice the bit rate. The bit clock is a registered divide-by-two of that master clock, and it is gated off while the codec is in reset, while it is waiting for start-up, while it is in deep power-down and while it is waking up.

The controller's active-low reset pin is brought into the master-clock domain through a two-flop synchronizer. Once synchronized, it overrides every other state. When it is released, the bit clock starts after a programmable delay. Codec-ready rises a programmable time after the first frame SYNC that arrives while the clock runs. A power-down request, decoded by the link engine from a control-register write, takes effect at the end-of-slot-2 pulse of the same frame. In power-down the clock and the data-enable are held low. A SYNC pulse of at least a programmable width, seen while the clock is stopped, wakes the link: the clock restarts a fixed number of cycles after SYNC falls. A warm wake keeps the operating-mode register, while a cold reset returns it to mode 0.

Top module: `link_pwr_seq`

## Requirements
- R1: While the synchronized reset is active (reset pin low), bit_clk, link_en, pdown and codec_ready read 0 and op_mode reads 0, whatever state the block was in. The override takes effect by the fourth master edge after the pin falls.
- R2: After the reset pin is released, bit_clk first reads high after the (START_DLY+2)-th master edge, where edge 1 is the first edge that samples the pin high.
- R3: While link_en is high, bit_clk inverts on every master edge.
- R4: While the link runs, a SYNC rising edge with codec_ready low starts a timer. codec_ready reads 1 after the (READY_DLY+3)-th edge, where edge 1 is the first edge that samples SYNC high. It then stays 1 until power-down or reset.
- R5: A pd_write pulse while running arms a request. At the next slot2_end pulse, pdown goes to 1 and link_en, bit_clk and codec_ready go to 0 on that same edge. Until that pulse, the link keeps running.
- R6: While pdown is 1, bit_clk and link_en stay 0, and mode writes leave op_mode unchanged.
- R7: While powered down, a SYNC high for fewer than WARM_MIN consecutive master edges is ignored: pdown stays 1 and bit_clk stays 0.
- R8: While powered down, a SYNC high for at least WARM_MIN edges is a warm reset. bit_clk first reads high after the (RESTART_DLY+3)-th edge, where edge 1 is the first edge that samples SYNC low again.
- R9: A warm reset leaves op_mode unchanged, and codec_ready rises again only through a new SYNC as in R4.
- R10: mode_we with link_en high loads op_mode from mode_wdata (2 bits, modes 0 to 3) on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset pin from the controller |
| sync_in | input | 1 | Frame SYNC from the controller, asynchronous while the clock is stopped |
| pd_write | input | 1 | One-cycle pulse: the link engine decoded a power-down control write in this frame |
| slot2_end | input | 1 | One-cycle frame-phase pulse at the end of slot 2 |
| mode_we | input | 1 | Operating-mode register write strobe |
| mode_wdata | input | 2 | New operating mode |
| bit_clk | output | 1 | Gated bit clock to the link |
| link_en | output | 1 | Link engine may shift and drive SDATA_IN; low forces it to 0 |
| pdown | output | 1 | Deep power-down active |
| codec_ready | output | 1 | Ready flag for the tag slot |
| op_mode | output | 2 | Current operating mode, which routes the second converter pair |

## Verification
The assertions assume that slot2_end and pd_write come from the link engine only while link_en is high, and that the parameters are at least 1. They also assume that SYNC is asynchronous, so every timing is counted from the edges of the synchronized copy. The stimulus changes inputs only on falling master edges. It sends slot2_end only while the link runs, and it draws warm-reset pulse widths at random from a narrow band around WARM_MIN, with the threshold and one cycle below it also driven directly. Each random width is compared against a bench function that decides whether the link should wake and with what latency.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WAKE  = 2'd3
  } lps_state_t;

  typedef logic [1:0] lps_mode_t;
  localparam lps_mode_t MODE_DEFAULT = 2'd0;
endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int START_DLY   = 1024,
  parameter int WARM_MIN    = 25,
  parameter int RESTART_DLY = 4
) (
  input  logic       clk,
  input  logic       cold,
  input  logic       sync_s,
  input  logic       pd_write,
  input  logic       slot2_end,
  output lps_state_t state,
  output lps_state_t state_nxt,
  output logic       bclk
);
  localparam int DMAX = (START_DLY > RESTART_DLY) ? START_DLY : RESTART_DLY;
  localparam int CW   = $clog2(DMAX + 1);
  localparam int WW   = $clog2(WARM_MIN + 1);

  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          pd_pend;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_START: if (cnt == CW'(START_DLY - 1)) state_nxt = ST_RUN;
      ST_RUN:   if (slot2_end && pd_pend) state_nxt = ST_PDOWN;
      ST_PDOWN: if (!sync_s && wcnt >= WW'(WARM_MIN)) state_nxt = ST_WAKE;
      ST_WAKE:  if (cnt == CW'(RESTART_DLY - 1)) state_nxt = ST_RUN;
      default:  state_nxt = ST_START;
    endcase
    if (cold) state_nxt = ST_START;
  end

  always_ff @(posedge clk) begin
    state <= state_nxt;
    bclk  <= (state_nxt == ST_RUN) ? ~bclk : 1'b0;

    if (cold || state_nxt != state) cnt <= '0;
    else if (state == ST_START || state == ST_WAKE) cnt <= cnt + 1'b1;

    if (cold || state != ST_PDOWN || !sync_s) wcnt <= '0;
    else if (wcnt < WW'(WARM_MIN)) wcnt <= wcnt + 1'b1;

    if (cold || state != ST_RUN || state_nxt == ST_PDOWN) pd_pend <= 1'b0;
    else if (pd_write) pd_pend <= 1'b1;
  end

  // R3: a running link produces a toggling clock every master edge
  p_bclk_toggle_r3: assert property (@(posedge clk) disable iff (cold)
    (state == ST_RUN && $past(state) == ST_RUN) |-> (bclk != $past(bclk)));

  // R5: power-down only entered from a running link on the slot-2 boundary
  p_pd_at_slot2_r5: assert property (@(posedge clk) disable iff (cold)
    (state == ST_PDOWN && $past(state) == ST_RUN) |-> $past(slot2_end));

  // R8: waking needs a SYNC pulse that reached the threshold
  p_wake_width_r8: assert property (@(posedge clk) disable iff (cold)
    (state == ST_WAKE && $past(state) == ST_PDOWN) |-> ($past(wcnt) >= WW'(WARM_MIN)));
endmodule

// File: rtl/lps_ready.sv
module lps_ready #(
  parameter int READY_DLY = 1534
) (
  input  logic clk,
  input  logic cold,
  input  logic run,
  input  logic run_nxt,
  input  logic sync_s,
  output logic ready
);
  localparam int RW = $clog2(READY_DLY + 1);

  logic          sync_d;
  logic          timing;
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk) begin
    sync_d <= sync_s;
    if (cold || !run_nxt) begin
      ready  <= 1'b0;
      timing <= 1'b0;
      rcnt   <= '0;
    end else if (timing) begin
      if (rcnt == RW'(READY_DLY - 1)) begin
        ready  <= 1'b1;
        timing <= 1'b0;
      end
      rcnt <= rcnt + 1'b1;
    end else if (run && !ready && sync_s && !sync_d) begin
      timing <= 1'b1;
      rcnt   <= '0;
    end
  end
endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq
  import lps_pkg::*;
#(
  parameter int START_DLY   = 1024,
  parameter int WARM_MIN    = 25,
  parameter int RESTART_DLY = 4,
  parameter int READY_DLY   = 1534,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       sync_in,
  input  logic       pd_write,
  input  logic       slot2_end,
  input  logic       mode_we,
  input  logic [1:0] mode_wdata,
  output logic       bit_clk,
  output logic       link_en,
  output logic       pdown,
  output logic       codec_ready,
  output logic [1:0] op_mode
);
  logic [1:0] pins_s;
  logic       cold, sync_s;
  lps_state_t state, state_nxt;
  lps_mode_t  mode_q;

  lps_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({cold_rst_n, sync_in}),
    .q   (pins_s)
  );
  assign cold   = ~pins_s[1];
  assign sync_s = pins_s[0];

  lps_fsm #(
    .START_DLY   (START_DLY),
    .WARM_MIN    (WARM_MIN),
    .RESTART_DLY (RESTART_DLY)
  ) u_fsm (
    .clk       (clk),
    .cold      (cold),
    .sync_s    (sync_s),
    .pd_write  (pd_write),
    .slot2_end (slot2_end),
    .state     (state),
    .state_nxt (state_nxt),
    .bclk      (bit_clk)
  );

  lps_ready #(.READY_DLY(READY_DLY)) u_ready (
    .clk     (clk),
    .cold    (cold),
    .run     (state == ST_RUN),
    .run_nxt (state_nxt == ST_RUN),
    .sync_s  (sync_s),
    .ready   (codec_ready)
  );

  always_ff @(posedge clk) begin
    if (cold) mode_q <= MODE_DEFAULT;
    else if (mode_we && state == ST_RUN) mode_q <= mode_wdata;
  end

  assign link_en = (state == ST_RUN);
  assign pdown   = (state == ST_PDOWN);
  assign op_mode = mode_q;

  // R6: clock held low during power-down
  p_pd_quiet_r6: assert property (@(posedge clk) disable iff (cold)
    pdown |-> (!bit_clk && !link_en));

  // R6: mode register frozen during power-down
  p_mode_frozen_r6: assert property (@(posedge clk) disable iff (cold)
    pdown |=> $stable(op_mode));

  // R4: ready is only reported on a running link
  p_ready_link_r4: assert property (@(posedge clk) disable iff (cold)
    codec_ready |-> link_en);
endmodule

// File: tb/link_pwr_seq_test.sv
module link_pwr_seq_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int START_DLY   = 5;
  localparam int WARM_MIN    = 8;
  localparam int RESTART_DLY = 3;
  localparam int READY_DLY   = 20;

  logic       clk = 1'b0;
  logic       cold_rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       pd_write = 1'b0;
  logic       slot2_end = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'd0;
  logic       bit_clk, link_en, pdown, codec_ready;
  logic [1:0] op_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  link_pwr_seq #(
    .START_DLY   (START_DLY),
    .WARM_MIN    (WARM_MIN),
    .RESTART_DLY (RESTART_DLY),
    .READY_DLY   (READY_DLY)
  ) uut (
    .clk, .cold_rst_n, .sync_in, .pd_write, .slot2_end, .mode_we, .mode_wdata,
    .bit_clk, .link_en, .pdown, .codec_ready, .op_mode
  );

  function automatic int exp_start_lat();
    return START_DLY + 2;
  endfunction

  function automatic int exp_wake_lat(input int w);
    return (w >= WARM_MIN) ? RESTART_DLY + 3 : 0;
  endfunction

  function automatic int exp_ready_lat();
    return READY_DLY + 3;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // kind 0: wait for bit_clk high; kind 1: wait for codec_ready, dropping SYNC after 2 edges
  task automatic count_edges(input int kind, input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (kind == 1 && i == 2) sync_in = 1'b0;
      if ((kind == 0) ? bit_clk : codec_ready) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic get_ready(input string rq);
    int n;
    sync_in = 1'b1;
    count_edges(1, 60, n);
    chk(rq, n, exp_ready_lat());
  endtask

  task automatic enter_pd();
    pd_write = 1'b1;
    step(1);
    pd_write = 1'b0;
    step(3);
    chk("R5 waits for slot 2", int'(link_en), 1);
    slot2_end = 1'b1;
    step(1);
    slot2_end = 1'b0;
    chk("R5 pdown", int'(pdown), 1);
    chk("R5 link_en", int'(link_en), 0);
    chk("R5 bit_clk", int'(bit_clk), 0);
    chk("R5 ready cleared", int'(codec_ready), 0);
  endtask

  task automatic warm_pulse(input int w, input logic [1:0] mode_exp);
    int n;
    sync_in = 1'b1;
    repeat (w) @(posedge clk);
    @(negedge clk);
    sync_in = 1'b0;
    count_edges(0, 40, n);
    if (w >= WARM_MIN) begin
      chk("R8 restart latency", n, exp_wake_lat(w));
      chk("R9 mode kept", int'(op_mode), int'(mode_exp));
      chk("R9 ready not yet", int'(codec_ready), 0);
      get_ready("R9 ready after warm");
      enter_pd();
    end else begin
      chk("R7 short pulse ignored", n, 0);
      chk("R7 still pdown", int'(pdown), 1);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int w;
    logic [1:0] m;
    void'($urandom(32'd1234));

    step(6);
    chk("R1 bit_clk in reset", int'(bit_clk), 0);
    chk("R1 link_en in reset", int'(link_en), 0);
    chk("R1 ready in reset", int'(codec_ready), 0);
    chk("R1 mode in reset", int'(op_mode), 0);

    cold_rst_n = 1'b1;
    count_edges(0, 40, n);
    chk("R2 start latency", n, exp_start_lat());

    for (int i = 0; i < 8; i++) begin
      logic prev;
      prev = bit_clk;
      step(1);
      chk("R3 toggle", int'(bit_clk), int'(!prev));
    end

    get_ready("R4 ready latency");
    step(10);
    chk("R4 ready held", int'(codec_ready), 1);

    m = 2'($urandom_range(1, 3));
    mode_wdata = m;
    mode_we = 1'b1;
    step(1);
    mode_we = 1'b0;
    chk("R10 mode write", int'(op_mode), int'(m));

    enter_pd();
    mode_wdata = ~m;
    mode_we = 1'b1;
    step(1);
    mode_we = 1'b0;
    chk("R6 mode ignored", int'(op_mode), int'(m));
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R6 clock low", int'(bit_clk), 0);
    end

    warm_pulse(WARM_MIN - 1, m);
    warm_pulse(WARM_MIN, m);
    for (int t = 0; t < 8; t++) begin
      w = WARM_MIN - 3 + int'($urandom_range(0, 5));
      warm_pulse(w, m);
    end

    warm_pulse(WARM_MIN + 2, m);
    sync_in = 1'b1;
    repeat (WARM_MIN + 2) @(posedge clk);
    @(negedge clk);
    sync_in = 1'b0;
    count_edges(0, 40, n);
    chk("R8 restart before reset", n, exp_wake_lat(WARM_MIN + 2));
    cold_rst_n = 1'b0;
    step(4);
    chk("R1 override bit_clk", int'(bit_clk), 0);
    chk("R1 override link_en", int'(link_en), 0);
    chk("R1 override mode", int'(op_mode), 0);
    step(3);
    chk("R1 held", int'(link_en), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule